// File: doc/BRIEF.md
# Fast PWM Timer Compare Unit

An 8-bit up-counter with two compare channels that produce pulse-width-modulated waveforms in single-slope mode. A prescaler turns the system clock into a timer tick at one of five division ratios. On each tick the counter steps up from zero to a top value and wraps back to zero on the next tick. Each channel compares the count with its active compare value and drives one output. The output mode of each channel makes it low, toggling, non-inverted or inverted.

Software sets the unit up through a one-cycle write strobe with a two-bit address. Compare writes land in buffer registers. A channel uses a new value only from the tick on which the counter wraps, so a period never mixes two duty cycles. Sticky flags record wraps and compare matches. Writing ones to the clear address clears them.

Top module: `pwm8_timer`

## Requirements
- R1: After reset the count, both outputs, all flags, all compare registers and the control register are zero, so the timer is stopped.
- R2: A write with wr_addr 0 loads the control register: bits 2:0 are the clock select, bit 3 is the top select, bits 5:4 are the channel A mode and bits 7:6 are the channel B mode. Address 1 loads the channel A compare buffer and address 2 loads the channel B compare buffer.
- R3: A 10-bit cycle counter runs freely from reset. With clock select 1, 2, 3, 4 or 5 a tick occurs on every cycle in which that counter modulo N equals N-1, for N = 1, 8, 64, 256 and 1024 respectively. Clock select 0, 6 or 7 gives no ticks, and the count holds.
- R4: On each tick the count rises by one, or goes to 0 when it equals TOP. TOP is 255 when the top select is 0 and the active channel A compare value when it is 1.
- R5: A channel's active compare value takes the buffer contents only on the tick where the count wraps from TOP.
- R6: The overflow flag sets on the tick where the count equals TOP.
- R7: A channel's match flag sets on a tick where the count equals that channel's active compare value.
- R8: Mode 2 (non-inverted) drives the output high on the wrap tick and low on a match tick. When both occur on the same tick, the wrap wins.
- R9: Mode 3 (inverted) drives the output low on the wrap tick and high on a match tick. When both occur on the same tick, the wrap wins.
- R10: Mode 1 inverts output A on each match tick, but only while the top select is 1. Otherwise mode 1 holds the output low, and output B is always low in mode 1.
- R11: Mode 0 holds the channel output low.
- R12: With TOP 255 in mode 2, a compare value of 0 gives a one-tick high pulse every 256 ticks. A compare value of 255 gives a constantly high output in mode 2 and a constantly low output in mode 3.
- R13: A write to address 3 clears each flag whose data bit is one: bit 0 is overflow, bit 1 is match A and bit 2 is match B. A flag being set on the same cycle wins over the clear.
- R14: With the top select at 1, active compare A at 0, mode 1 and division 1, output A inverts on every clock, which is half the clock frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare A, 2 compare B, 3 flag clear |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_match_a | output | 1 | Sticky channel A match flag |
| flag_match_b | output | 1 | Sticky channel B match flag |

## Verification
The assertions assume that reset is asserted before the first write. They also assume that wr_addr and wr_data are valid whenever wr_en is high and are sampled only at the rising edge. The mode-dependent properties refer to the mode held in the control register on the cycle before the output is checked, so they stay valid when software changes modes while the timer runs. The stimulus drives every input on the falling edge and raises wr_en for exactly one cycle per write. Every write goes through one of the four defined addresses.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam int PRESC_W = 10;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  // Low-bit mask whose all-ones state marks a tick for a clock select.
  function automatic logic [PRESC_W-1:0] presc_mask(input logic [2:0] csel);
    case (csel)
      3'd2:    presc_mask = PRESC_W'(7);
      3'd3:    presc_mask = PRESC_W'(63);
      3'd4:    presc_mask = PRESC_W'(255);
      3'd5:    presc_mask = PRESC_W'(1023);
      default: presc_mask = '0;
    endcase
  endfunction

  function automatic logic presc_run(input logic [2:0] csel);
    presc_run = (csel >= 3'd1) && (csel <= 3'd5);
  endfunction

  // Next waveform level. wrap and hit are already qualified by the tick.
  function automatic logic next_wave(input out_mode_e m, input logic tog_ok,
                                     input logic wrap, input logic hit,
                                     input logic cur);
    case (m)
      OM_NONINV: next_wave = wrap ? 1'b1 : (hit ? 1'b0 : cur);
      OM_INV:    next_wave = wrap ? 1'b0 : (hit ? 1'b1 : cur);
      OM_TOGGLE: next_wave = tog_ok ? (hit ? ~cur : cur) : 1'b0;
      default:   next_wave = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
  import pwm8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] csel,
  output logic       tick
);

  logic [PRESC_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = presc_run(csel) &&
                ((pre_q & presc_mask(csel)) == presc_mask(csel));

endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic         wrap
);

  assign wrap = tick && (count == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
  import pwm8_pkg::*;
#(
  parameter int W         = 8,
  parameter bit TOGGLE_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] count,
  input  logic [W-1:0] buf_val,
  input  logic         top_sel,
  input  logic [1:0]   mode,
  output logic         wave,
  output logic [W-1:0] act,
  output logic         match
);

  logic tog_ok;

  assign tog_ok = TOGGLE_OK && top_sel;
  assign match  = tick && (count == act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= '0;
      wave <= 1'b0;
    end else begin
      if (wrap) act <= buf_val;
      wave <= next_wave(out_mode_e'(mode), tog_ok, wrap, match, wave);
    end
  end

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             wave_a,
  output logic             wave_b,
  output logic             flag_ovf,
  output logic             flag_match_a,
  output logic             flag_match_b
);

  localparam int NCH = 2;

  logic [2:0]       csel_q;
  logic             top_sel_q;
  logic [1:0]       mode_q  [NCH];
  logic [CNT_W-1:0] cmp_buf [NCH];
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [NCH-1:0]   wave_v;
  logic [NCH-1:0]   match_v;

  // Named internal events.
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] top_val;
  logic [1:0]       mode_a_q;
  logic [1:0]       mode_b_q;
  logic [2:0]       flag_clr;
  logic             match_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q    <= '0;
      top_sel_q <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        mode_q[i]  <= '0;
        cmp_buf[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          csel_q    <= wr_data[2:0];
          top_sel_q <= wr_data[3];
          mode_q[0] <= wr_data[5:4];
          mode_q[1] <= wr_data[7:6];
        end
        2'd1:    cmp_buf[0] <= wr_data;
        2'd2:    cmp_buf[1] <= wr_data;
        default: ;
      endcase
    end
  end

  assign flag_clr = (wr_en && wr_addr == 2'd3) ? wr_data[2:0] : 3'b000;
  assign mode_a_q = mode_q[0];
  assign mode_b_q = mode_q[1];
  assign top_val  = top_sel_q ? cmp_act[0] : {CNT_W{1'b1}};
  assign match_a  = match_v[0];

  pwm8_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .csel  (csel_q),
    .tick  (tick)
  );

  pwm8_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .top   (top_val),
    .count (count),
    .wrap  (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm8_channel #(.W(CNT_W), .TOGGLE_OK(g == 0)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wrap    (wrap),
      .count   (count),
      .buf_val (cmp_buf[g]),
      .top_sel (top_sel_q),
      .mode    (mode_q[g]),
      .wave    (wave_v[g]),
      .act     (cmp_act[g]),
      .match   (match_v[g])
    );
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_ovf     <= 1'b0;
      flag_match_a <= 1'b0;
      flag_match_b <= 1'b0;
    end else begin
      flag_ovf     <= wrap       | (flag_ovf     & ~flag_clr[0]);
      flag_match_a <= match_v[0] | (flag_match_a & ~flag_clr[1]);
      flag_match_b <= match_v[1] | (flag_match_b & ~flag_clr[2]);
    end
  end

endmodule

// File: rtl/pwm8_timer_checker.sv
module pwm8_timer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wrap,
  input logic [W-1:0] count,
  input logic         wave_a,
  input logic         wave_b,
  input logic [1:0]   mode_a,
  input logic [1:0]   mode_b,
  input logic         flag_ovf,
  input logic         flag_match_a,
  input logic [2:0]   clr,
  input logic         match_a
);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wrap |=> count == W'($past(count) + 1));

  assert_count_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_ovf);

  assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> flag_match_a);

  assert_ovf_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf && !clr[0] |=> flag_ovf);

  assert_noninv_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode_a == 2'd2 |=> wave_a);

  assert_inv_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode_a == 2'd3 |=> !wave_a);

  assert_b_no_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_b == 2'd1 |=> !wave_b);

  assert_off_low_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_a == 2'd0 |=> !wave_a);

  assert_off_low_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_b == 2'd0 |=> !wave_b);

endmodule

bind pwm8_timer pwm8_timer_checker #(.W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .wrap         (wrap),
  .count        (count),
  .wave_a       (wave_a),
  .wave_b       (wave_b),
  .mode_a       (mode_a_q),
  .mode_b       (mode_b_q),
  .flag_ovf     (flag_ovf),
  .flag_match_a (flag_match_a),
  .clr          (flag_clr),
  .match_a      (match_a)
);

// File: tb/pwm8_timer_test.sv
module pwm8_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       wave_a, wave_b, flag_ovf, flag_match_a, flag_match_b;

  int vectors = 0;
  int fails = 0;

  pwm8_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .wave_a(wave_a), .wave_b(wave_b),
    .flag_ovf(flag_ovf), .flag_match_a(flag_match_a),
    .flag_match_b(flag_match_b)
  );

  always #5 clk = ~clk;

  // Reference model built from the requirements.
  logic [9:0] m_pre;
  logic [2:0] m_csel;
  logic       m_tsel;
  logic [1:0] m_mode_a, m_mode_b;
  logic [7:0] m_buf_a, m_buf_b, m_act_a, m_act_b, m_cnt;
  logic       m_wa, m_wb, m_fo, m_fa, m_fb;
  logic       mt_tick, mt_wrap, mt_hit_a, mt_hit_b;
  int         mt_rate;

  always_comb begin
    case (m_csel)
      3'd1: mt_rate = 1;
      3'd2: mt_rate = 8;
      3'd3: mt_rate = 64;
      3'd4: mt_rate = 256;
      3'd5: mt_rate = 1024;
      default: mt_rate = 0;
    endcase
    mt_tick  = (mt_rate != 0) && ((int'(m_pre) % mt_rate) == mt_rate - 1);
    mt_wrap  = mt_tick && (m_cnt == (m_tsel ? m_act_a : 8'd255));
    mt_hit_a = mt_tick && (m_cnt == m_act_a);
    mt_hit_b = mt_tick && (m_cnt == m_act_b);
  end

  function automatic logic ref_wave(input logic [1:0] md, input logic tog,
                                    input logic wr, input logic hit,
                                    input logic cur);
    if (md == 2'd2)      return wr | (cur & ~hit);
    else if (md == 2'd3) return ~wr & (cur | hit);
    else if (md == 2'd1 && tog) return cur ^ hit;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= '0; m_csel <= '0; m_tsel <= 1'b0; m_mode_a <= '0; m_mode_b <= '0;
      m_buf_a <= '0; m_buf_b <= '0; m_act_a <= '0; m_act_b <= '0; m_cnt <= '0;
      m_wa <= 1'b0; m_wb <= 1'b0; m_fo <= 1'b0; m_fa <= 1'b0; m_fb <= 1'b0;
    end else begin
      m_pre <= m_pre + 10'd1;
      if (wr_en && wr_addr == 2'd0) begin
        m_csel <= wr_data[2:0]; m_tsel <= wr_data[3];
        m_mode_a <= wr_data[5:4]; m_mode_b <= wr_data[7:6];
      end
      if (wr_en && wr_addr == 2'd1) m_buf_a <= wr_data;
      if (wr_en && wr_addr == 2'd2) m_buf_b <= wr_data;
      if (mt_wrap) begin
        m_cnt <= 8'd0; m_act_a <= m_buf_a; m_act_b <= m_buf_b;
      end else if (mt_tick) m_cnt <= m_cnt + 8'd1;
      m_wa <= ref_wave(m_mode_a, m_tsel, mt_wrap, mt_hit_a, m_wa);
      m_wb <= ref_wave(m_mode_b, 1'b0, mt_wrap, mt_hit_b, m_wb);
      m_fo <= mt_wrap  || (m_fo && !(wr_en && wr_addr == 2'd3 && wr_data[0]));
      m_fa <= mt_hit_a || (m_fa && !(wr_en && wr_addr == 2'd3 && wr_data[1]));
      m_fb <= mt_hit_b || (m_fb && !(wr_en && wr_addr == 2'd3 && wr_data[2]));
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Compare every output with the model for n cycles.
  task automatic track(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, "count", count, m_cnt);
      check(req, "wave_a", wave_a, m_wa);
      check(req, "wave_b", wave_b, m_wb);
      check(req, "flags", {flag_ovf, flag_match_a, flag_match_b}, {m_fo, m_fa, m_fb});
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "count", count, 0);
    check("R1", "waves", {wave_a, wave_b}, 0);
    check("R1", "flags", {flag_ovf, flag_match_a, flag_match_b}, 0);
    repeat (20) @(negedge clk);
    check("R1", "count stopped", count, 0);
  endtask

  task automatic measure(input int sel, input int n);
    logic [7:0] prev;
    int cyc;
    wr(2'd0, 8'(sel));
    prev = count; cyc = 0;
    while (count == prev && cyc < 3000) begin @(negedge clk); cyc++; end
    prev = count; cyc = 0;
    while (count == prev && cyc < 3000) begin @(negedge clk); cyc++; end
    check("R3", $sformatf("tick interval sel %0d", sel), cyc, n);
  endtask

  task automatic t_prescale;
    logic [7:0] hold;
    measure(1, 1);
    measure(2, 8);
    measure(3, 64);
    measure(4, 256);
    measure(5, 1024);
    wr(2'd0, 8'd6);
    hold = count;
    repeat (100) @(negedge clk);
    check("R3", "sel 6 holds", count, hold);
    wr(2'd0, 8'd0);
    hold = count;
    repeat (1500) @(negedge clk);
    check("R3", "sel 0 holds", count, hold);
  endtask

  task automatic t_noninv;
    wr(2'd1, 8'd64);
    wr(2'd2, 8'd192);
    wr(2'd0, 8'hA1);  // R2: A and B mode 2, division 1
    track(600, "R8");
    wr(2'd0, 8'hE1);  // A mode 2, B mode 3
    track(600, "R9");
  endtask

  task automatic t_inverted;
    wr(2'd1, 8'd40);
    wr(2'd2, 8'd200);
    wr(2'd0, 8'hF1);
    track(600, "R9");
  endtask

  task automatic t_buffer;
    wr(2'd1, 8'd100);
    wr(2'd0, 8'h21);  // A mode 2
    repeat (300) @(negedge clk);
    while (count != 8'd10) @(negedge clk);
    wr(2'd1, 8'd200);
    while (count != 8'd150) @(negedge clk);
    check("R5", "old compare kept in period", wave_a, 0);
    while (count != 8'd50) @(negedge clk);
    while (count != 8'd150) @(negedge clk);
    check("R5", "new compare after wrap", wave_a, 1);
    track(300, "R5");
  endtask

  task automatic t_extremes;
    int highs;
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h21);
    repeat (300) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (wave_a) highs++;
    end
    check("R12", "spike high cycles in 512", highs, 2);
    wr(2'd1, 8'd255);
    repeat (300) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (wave_a) highs++;
    end
    check("R12", "compare MAX mode 2 constant high", highs, 512);
    wr(2'd0, 8'h31);
    repeat (300) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (wave_a) highs++;
    end
    check("R12", "compare MAX mode 3 constant low", highs, 0);
    track(300, "R12");
  endtask

  task automatic t_toggle;
    logic prev;
    int highs;
    wr(2'd1, 8'd30);
    wr(2'd0, 8'h11);  // mode 1 without top select
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wave_a) highs++;
    end
    check("R10", "mode 1 without top select low", highs, 0);
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h59);  // top select, A and B mode 1
    track(400, "R10");
    wr(2'd1, 8'd0);
    repeat (300) @(negedge clk);
    check("R14", "count held at TOP 0", count, 0);
    prev = wave_a;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R14", "wave_a inverts each clock", wave_a, !prev);
      check("R10", "wave_b low in mode 1", wave_b, 0);
      prev = wave_a;
    end
  endtask

  task automatic t_flags;
    wr(2'd1, 8'd10);
    wr(2'd2, 8'd20);
    wr(2'd0, 8'hA1);
    track(300, "R7");
    wr(2'd0, 8'hA0);  // stop
    @(negedge clk);
    check("R6", "overflow flag", flag_ovf, 1);
    check("R7", "match flags", {flag_match_a, flag_match_b}, 3);
    wr(2'd3, 8'h02);
    check("R13", "clear match A only", {flag_ovf, flag_match_a, flag_match_b}, 3'b101);
    wr(2'd3, 8'h05);
    check("R13", "clear rest", {flag_ovf, flag_match_a, flag_match_b}, 0);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h09);  // top select, division 1: wraps on every tick once loaded
    repeat (300) @(negedge clk);
    wr(2'd3, 8'h01);
    check("R13", "set wins over clear", flag_ovf, 1);
    track(50, "R13");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_noninv();
    t_inverted();
    t_buffer();
    t_extremes();
    t_toggle();
    t_flags();
    finish_run();
  end

endmodule